// File: doc/BRIEF.md
# Processor Status Word with Interrupt Gating

This block holds the eight-bit status word of a small eight-bit CPU core: the interrupt enable, zero, auxiliary carry and carry flags, two register bank select bits, and the in-service priority flag. Decoded-instruction strobes update it: disable interrupts, enable interrupts, interrupt acknowledge, status push, status pop/return, and per-flag writes from the ALU. A byte bus returns a previously stacked value when a pop, a return from interrupt or a return from break executes.

The current word is always on an output so that the stack logic can save it. A qualifier marks the cycles in which it must be saved: an interrupt acknowledge or a push. For each interrupt source, a combinational gate decides whether a pending maskable request may be acknowledged. It combines the enable flag, the in-service priority flag, and that source's mask and priority bits. The number of sources and the polarity of the priority bit are parameters.

Top module: `cpu_status_word`

## Requirements
- R1: While reset is asserted, and after it is released, the word reads 02h: only the in-service priority flag is set and interrupts are disabled.
- R2: Bit positions are IE=7, Z=6, RBS1=5, AC=4, RBS0=3, ISP=1 and CY=0. Bit 2 always reads 0, even after a restore that drives it to 1.
- R3: `dis_stb` clears IE at the next clock edge.
- R4: `ena_stb` sets IE at the next clock edge. When `ena_stb` and `dis_stb` occur together, IE ends at 0.
- R5: `ack_stb` clears IE at the next clock edge and wins over `ena_stb` and over a restore in the same cycle.
- R6: `stack_word` always equals the current word. `stack_valid` is high in exactly the cycles where `ack_stb` or `push_stb` is high.
- R7: `pop_stb` loads `restore_bus` (bit 2 forced to 0) at the next clock edge. The IE rules of R3 to R5 apply on top of the load.
- R8: Each of `z_we`, `ac_we` and `cy_we` loads only its own flag from its value input and leaves every other bit unchanged. A restore in the same cycle overrides all ALU writes.
- R9: With the default priority polarity (0 = high), `ack_permit[i] = IE & irq_req[i] & ~irq_mask[i] & (~irq_prio[i] | ISP)`. The gate is combinational and reflects the same cycle's inputs.
- R10: While IE is 0, `ack_permit` is all zeros, whatever the request, mask and priority inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dis_stb | input | 1 | Disable-interrupts instruction executed |
| ena_stb | input | 1 | Enable-interrupts instruction executed |
| ack_stb | input | 1 | Interrupt acknowledged |
| push_stb | input | 1 | Push of status word executed |
| pop_stb | input | 1 | Pop of status word or return from interrupt/break executed |
| restore_bus | input | 8 | Stacked word to reload |
| z_we | input | 1 | Zero flag write enable |
| z_val | input | 1 | Zero flag value |
| ac_we | input | 1 | Auxiliary carry write enable |
| ac_val | input | 1 | Auxiliary carry value |
| cy_we | input | 1 | Carry write enable |
| cy_val | input | 1 | Carry value |
| irq_req | input | NUM_SRC | Pending request per source |
| irq_mask | input | NUM_SRC | Mask per source (1 = masked) |
| irq_prio | input | NUM_SRC | Priority bit per source |
| status_word | output | 8 | Current status word |
| stack_word | output | 8 | Word to be stacked |
| stack_valid | output | 1 | Save the word this cycle |
| ack_permit | output | NUM_SRC | Acknowledge allowed per source |

## Verification
A wrong bit in the status register shows on `status_word` one clock after the strobe that caused it. When IE or ISP is wrong, it also shows at once on `ack_permit`, so a lost or stray IE change blocks or admits a request in the very next cycle. Bit-position errors and a stuck bit 2 show up in the first restore that drives all ones or an alternating pattern. The interactions between strobes (acknowledge against restore, disable against enable, restore against ALU writes) need coincident strobes, which both the random stimulus and the directed cases supply.

// File: rtl/stw_pkg.sv
package stw_pkg;
   localparam int WORD_W   = 8;
   localparam int B_IE     = 7;
   localparam int B_Z      = 6;
   localparam int B_RBS1   = 5;
   localparam int B_AC     = 4;
   localparam int B_RBS0   = 3;
   localparam int B_ZERO   = 2;
   localparam int B_ISP    = 1;
   localparam int B_CY     = 0;
   localparam logic [WORD_W-1:0] RESET_WORD = 8'h02;
   localparam logic [WORD_W-1:0] LIVE_MASK  = ~(8'h01 << B_ZERO);
endpackage

// File: rtl/stw_flags.sv
module stw_flags
   import stw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dis_stb,
   input  logic              ena_stb,
   input  logic              ack_stb,
   input  logic              pop_stb,
   input  logic [WORD_W-1:0] restore_bus,
   input  logic              z_we,
   input  logic              z_val,
   input  logic              ac_we,
   input  logic              ac_val,
   input  logic              cy_we,
   input  logic              cy_val,
   output logic [WORD_W-1:0] word
);
   logic [WORD_W-1:0] nxt;

   always_comb begin
      nxt = word;
      if (pop_stb) begin
         nxt = restore_bus;
      end else begin
         if (z_we)  nxt[B_Z]  = z_val;
         if (ac_we) nxt[B_AC] = ac_val;
         if (cy_we) nxt[B_CY] = cy_val;
      end
      if (ack_stb || dis_stb) nxt[B_IE] = 1'b0;
      else if (ena_stb)       nxt[B_IE] = 1'b1;
      nxt = nxt & LIVE_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word <= RESET_WORD;
      else        word <= nxt;
   end

   // R3
   p_dis_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dis_stb |=> !word[B_IE]);
   // R5
   p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> !word[B_IE]);
   // R4
   p_ena_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_stb && !dis_stb && !ack_stb) |=> word[B_IE]);
   // R7
   p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_stb && !dis_stb && !ena_stb && !ack_stb) |=>
         word == ($past(restore_bus) & LIVE_MASK));
   // R8
   p_alu_isolate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop_stb && !dis_stb && !ena_stb && !ack_stb) |=>
         (word[B_RBS1] == $past(word[B_RBS1]) && word[B_RBS0] == $past(word[B_RBS0])
          && word[B_ISP] == $past(word[B_ISP]) && word[B_IE] == $past(word[B_IE])));
   // R2
   p_bit2_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pop_stb |=> !word[B_ZERO]);
endmodule

// File: rtl/stw_irq_gate.sv
module stw_irq_gate #(
   parameter int NUM_SRC    = 8,
   parameter int HIGH_LEVEL = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ie,
   input  logic               isp,
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] mask,
   input  logic [NUM_SRC-1:0] prio,
   output logic [NUM_SRC-1:0] permit
);
   logic [NUM_SRC-1:0] is_high;

   generate
      if (HIGH_LEVEL == 0) begin : g_low_is_high
         assign is_high = ~prio;
      end else begin : g_one_is_high
         assign is_high = prio;
      end
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         assign permit[i] = ie & req[i] & ~mask[i] & (is_high[i] | isp);
      end
   endgenerate

   // R10
   p_ie_low_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ie |-> (permit == '0));
   // R9
   p_masked_never_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (permit & mask) == '0);
endmodule

// File: rtl/cpu_status_word.sv
module cpu_status_word #(
   parameter int NUM_SRC    = 8,
   parameter int HIGH_LEVEL = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dis_stb,
   input  logic               ena_stb,
   input  logic               ack_stb,
   input  logic               push_stb,
   input  logic               pop_stb,
   input  logic [7:0]         restore_bus,
   input  logic               z_we,
   input  logic               z_val,
   input  logic               ac_we,
   input  logic               ac_val,
   input  logic               cy_we,
   input  logic               cy_val,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [NUM_SRC-1:0] irq_mask,
   input  logic [NUM_SRC-1:0] irq_prio,
   output logic [7:0]         status_word,
   output logic [7:0]         stack_word,
   output logic               stack_valid,
   output logic [NUM_SRC-1:0] ack_permit
);
   import stw_pkg::*;

   generate
      if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_src
         $error("NUM_SRC must lie in 1..64");
      end
      if (HIGH_LEVEL != 0 && HIGH_LEVEL != 1) begin : g_bad_level
         $error("HIGH_LEVEL must be 0 or 1");
      end
   endgenerate

   logic [WORD_W-1:0] word;

   stw_flags u_flags (
      .clk(clk), .rst_n(rst_n),
      .dis_stb(dis_stb), .ena_stb(ena_stb), .ack_stb(ack_stb), .pop_stb(pop_stb),
      .restore_bus(restore_bus),
      .z_we(z_we), .z_val(z_val), .ac_we(ac_we), .ac_val(ac_val),
      .cy_we(cy_we), .cy_val(cy_val),
      .word(word)
   );

   stw_irq_gate #(.NUM_SRC(NUM_SRC), .HIGH_LEVEL(HIGH_LEVEL)) u_gate (
      .clk(clk), .rst_n(rst_n),
      .ie(word[B_IE]), .isp(word[B_ISP]),
      .req(irq_req), .mask(irq_mask), .prio(irq_prio),
      .permit(ack_permit)
   );

   assign status_word = word;
   assign stack_word  = word;
   assign stack_valid = ack_stb | push_stb;

   // R6
   p_stack_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push_stb |-> stack_valid && stack_word == status_word);
endmodule

// File: tb/sim_cpu_status_word.sv
module sim_cpu_status_word;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dis_stb = 0, ena_stb = 0, ack_stb = 0, push_stb = 0, pop_stb = 0;
   logic [7:0] restore_bus = '0;
   logic z_we = 0, z_val = 0, ac_we = 0, ac_val = 0, cy_we = 0, cy_val = 0;
   logic [N-1:0] irq_req = '0, irq_mask = '0, irq_prio = '0;
   logic [7:0] status_word, stack_word;
   logic stack_valid;
   logic [N-1:0] ack_permit;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [7:0] model;

   always #10 clk = ~clk;

   cpu_status_word #(.NUM_SRC(N)) u0 (
      .clk(clk), .rst_n(rst_n), .dis_stb(dis_stb), .ena_stb(ena_stb), .ack_stb(ack_stb),
      .push_stb(push_stb), .pop_stb(pop_stb), .restore_bus(restore_bus),
      .z_we(z_we), .z_val(z_val), .ac_we(ac_we), .ac_val(ac_val),
      .cy_we(cy_we), .cy_val(cy_val),
      .irq_req(irq_req), .irq_mask(irq_mask), .irq_prio(irq_prio),
      .status_word(status_word), .stack_word(stack_word), .stack_valid(stack_valid),
      .ack_permit(ack_permit)
   );

   function automatic logic [7:0] next_word(logic [7:0] cur);
      logic [7:0] n = cur;
      if (pop_stb) n = restore_bus;
      else begin
         if (z_we)  n[6] = z_val;
         if (ac_we) n[4] = ac_val;
         if (cy_we) n[0] = cy_val;
      end
      if (ack_stb || dis_stb) n[7] = 1'b0;
      else if (ena_stb)       n[7] = 1'b1;
      n[2] = 1'b0;
      return n;
   endfunction

   function automatic logic [N-1:0] exp_permit(logic [7:0] w);
      return {N{w[7]}} & irq_req & ~irq_mask & (~irq_prio | {N{w[1]}});
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_in();
      {dis_stb, ena_stb, ack_stb, push_stb, pop_stb} = '0;
      {z_we, ac_we, cy_we} = '0;
      restore_bus = '0;
   endtask

   // drive at negedge, check combinational outputs, clock, check word
   task automatic step(string tag);
      #2;
      chk({tag, " R9 permit"}, 32'(ack_permit), 32'(exp_permit(model)));
      if (!model[7]) chk({tag, " R10 permit idle"}, 32'(ack_permit), 0);
      chk({tag, " R6 stack word"}, 32'(stack_word), 32'(model));
      chk({tag, " R6 stack valid"}, 32'(stack_valid), 32'(ack_stb | push_stb));
      @(posedge clk);
      model = next_word(model);
      @(negedge clk);
      chk({tag, " word"}, 32'(status_word), 32'(model));
   endtask

   initial begin
      void'($urandom(32'd4242));
      model = 8'h02;
      repeat (3) @(negedge clk);
      chk("R1 word in reset", 32'(status_word), 32'h02);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 word after reset", 32'(status_word), 32'h02);

      // R10: IE=0 with everything requesting
      irq_req = '1; irq_mask = '0; irq_prio = '0;
      step("R10 ie0");
      // R4: enable and disable together -> disable wins
      ena_stb = 1; dis_stb = 1; step("R4 both"); clear_in();
      chk("R4 both IE", 32'(status_word[7]), 0);
      ena_stb = 1; step("R4 ena"); clear_in();
      chk("R4 IE set", 32'(status_word[7]), 1);
      // R9 with ISP=1 and mixed priorities
      irq_prio = 8'hA5; irq_mask = 8'h0F; step("R9 isp1");
      // R2: restore all ones -> bit 2 low, IE set
      pop_stb = 1; restore_bus = 8'hFF; step("R2 restore ff"); clear_in();
      chk("R2 bit2 zero", 32'(status_word), 32'hFB);
      // R9 with ISP=1 after restore; then ISP=0 blocks low priority
      pop_stb = 1; restore_bus = 8'h80; step("R7 restore 80"); clear_in();
      irq_mask = '0; irq_prio = 8'hF0; step("R9 isp0");
      chk("R9 low prio blocked", 32'(ack_permit), 32'h0F);
      // R5: ack with pop restoring IE=1 and ena -> IE 0
      ack_stb = 1; ena_stb = 1; pop_stb = 1; restore_bus = 8'hAA; step("R5 ack wins"); clear_in();
      chk("R5 IE cleared", 32'(status_word), 32'h2A);
      // R8: restore overrides ALU writes
      pop_stb = 1; restore_bus = 8'h55; z_we = 1; z_val = 1; cy_we = 1; cy_val = 0;
      step("R8 restore over alu"); clear_in();
      chk("R8 restore value", 32'(status_word), 32'h51);
      // R8: single flag write
      ac_we = 1; ac_val = 0; step("R8 ac only"); clear_in();
      chk("R8 ac cleared", 32'(status_word), 32'h41);
      // R6 push
      push_stb = 1; step("R6 push"); clear_in();
      // R3
      ena_stb = 1; step("R3 pre"); clear_in();
      dis_stb = 1; step("R3 dis"); clear_in();
      chk("R3 IE cleared", 32'(status_word[7]), 0);

      for (int k = 0; k < 3000; k++) begin
         dis_stb  = ($urandom % 6) == 0;
         ena_stb  = ($urandom % 3) == 0;
         ack_stb  = ($urandom % 8) == 0;
         push_stb = ($urandom % 6) == 0;
         pop_stb  = ($urandom % 7) == 0;
         restore_bus = 8'($urandom);
         z_we = $urandom % 2; z_val = $urandom % 2;
         ac_we = $urandom % 2; ac_val = $urandom % 2;
         cy_we = $urandom % 2; cy_val = $urandom % 2;
         irq_req = N'($urandom); irq_mask = N'($urandom); irq_prio = N'($urandom);
         step("R7 R8 R9 random");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule